// File: doc/BRIEF.md
# Floating-Point Compare Unit

This unit compares two IEEE-754 double-precision operands and turns the outcome into a 4-bit one-hot condition code. When a compare is accepted, the code replaces one selectable 4-bit field of a 32-bit condition register. The same code is also copied into the condition-code bits of a 32-bit floating-point status register. Both registers live inside the unit and are visible on its outputs.

Two variants are offered. The unordered compare always reports a result, including "unordered" when a NaN is present. The ordered compare instead raises an invalid-operation trap when either operand is a NaN, and then leaves both registers untouched. A destination specifier whose low alignment bits are non-zero marks the request as illegal, and nothing is written. Quiet and signalling NaNs are handled alike, and no sticky exception bits are maintained.

Top module: `fp_compare_unit`

## Requirements
- R1: An operand whose exponent field is all ones and whose fraction is non-zero is a NaN. If either operand is a NaN, the unordered variant produces code 4'b0001 and tests no other relation.
- R2: For non-NaN operands the code is equal (4'b0010), less-than (4'b1000) or greater-than (4'b0100). These are tested in that priority order, and exactly one bit is set.
- R3: +0 and -0 compare equal.
- R4: Ordering follows sign and magnitude. A negative value is below a positive one, the magnitude order is inverted when both operands are negative, and infinities (all-ones exponent, zero fraction) act as the extreme values.
- R5: If bits 1:0 of the destination specifier are non-zero, `illegal_q` is high in the cycle after the strobe, and neither register changes.
- R6: The field index is the destination specifier shifted right by two (bits 4:2). Field 0 is condition-register bits 31:28, and field k is bits 31-4k down to 28-4k. The selected field is replaced in full, and the other fields keep their values.
- R7: On a write, status-register bit 15 is cleared and bits 14:11 take the code. All other status bits keep their values.
- R8: In the ordered variant (`in_ordered`=1), a NaN operand makes `trap_q` high in the cycle after the strobe, and neither register changes. Without a NaN, the ordered variant writes the same result as the unordered one.
- R9: Register updates and flags appear on the clock edge after `in_valid`, and each flag lasts one cycle. An illegal specifier takes precedence over a trap. While `in_valid` is low, the inputs have no effect.
- R10: After reset the condition register holds 32'h1234_5678, the status register holds 32'h0000_8A5F, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare request strobe |
| in_ordered | input | 1 | 1 selects the ordered (trapping) variant |
| in_a | input | 64 | First operand, double precision |
| in_b | input | 64 | Second operand, double precision |
| in_dest | input | 5 | Destination field specifier |
| cr_q | output | 32 | Condition register |
| fsr_q | output | 32 | Floating-point status register |
| illegal_q | output | 1 | Misaligned destination specifier seen |
| trap_q | output | 1 | Invalid-operation trap from an ordered compare |

## Verification
The case hardest to reach is a request that is both illegal and an ordered compare with a NaN operand. Only the precedence rule decides which flag appears, and the state that must stay unchanged is a register the bench has already modified. The stimulus first writes several fields and clears status bit 15 with legal compares. It then issues the combined request, so that a wrong flag or a stray write shows up against a known non-reset value. Fraction patterns with only the lowest bit set, together with infinities, probe the NaN boundary from both sides.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
   localparam int CC_W = 4;

   typedef enum logic [CC_W-1:0] {
      CC_LT = 4'b1000,
      CC_GT = 4'b0100,
      CC_EQ = 4'b0010,
      CC_UN = 4'b0001
   } cc_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [OP_W-1:0] op,
   output logic            is_nan,
   output logic            is_zero
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f   = op[OP_W-2 -: EXP_W];
   assign frac_f  = op[FRAC_W-1:0];
   assign is_nan  = (&exp_f) && (|frac_f);
   assign is_zero = ~|op[OP_W-2:0];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
   import fpcmp_pkg::*;
#(
   parameter int OP_W = 64
) (
   input  logic [OP_W-1:0] a,
   input  logic [OP_W-1:0] b,
   input  logic            a_nan,
   input  logic            b_nan,
   input  logic            a_zero,
   input  logic            b_zero,
   output cc_e             code
);
   logic [OP_W-2:0] mag_a, mag_b;
   logic            sgn_a, sgn_b;
   logic            mag_lt, a_below;

   assign mag_a  = a[OP_W-2:0];
   assign mag_b  = b[OP_W-2:0];
   assign sgn_a  = a[OP_W-1];
   assign sgn_b  = b[OP_W-1];
   assign mag_lt = mag_a < mag_b;

   always_comb begin
      if (sgn_a != sgn_b) a_below = sgn_a;
      else if (sgn_a)     a_below = !mag_lt;
      else                a_below = mag_lt;
   end

   always_comb begin
      if (a_nan || b_nan)                code = CC_UN;
      else if ((a_zero && b_zero) || (a == b)) code = CC_EQ;
      else if (a_below)                  code = CC_LT;
      else                               code = CC_GT;
   end
endmodule

// File: rtl/fpcmp_field_write.sv
module fpcmp_field_write #(
   parameter int FIELDS  = 8,
   parameter int FIELD_W = 4,
   localparam int IDX_W  = (FIELDS > 1) ? $clog2(FIELDS) : 1,
   localparam int REG_W  = FIELDS * FIELD_W
) (
   input  logic [REG_W-1:0]   cur,
   input  logic [IDX_W-1:0]   idx,
   input  logic [FIELD_W-1:0] val,
   output logic [REG_W-1:0]   nxt
);
   for (genvar i = 0; i < FIELDS; i++) begin : g_field
      localparam int LSB = (FIELDS - 1 - i) * FIELD_W;
      assign nxt[LSB +: FIELD_W] = (idx == IDX_W'(i)) ? val : cur[LSB +: FIELD_W];
   end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
   import fpcmp_pkg::*;
#(
   parameter int          EXP_W      = 11,
   parameter int          FRAC_W     = 52,
   parameter int          CR_FIELDS  = 8,
   parameter int          DEST_W     = 5,
   parameter int          FSR_W      = 32,
   parameter int          FSR_CC_LSB = 11,
   parameter logic [31:0] CR_INIT    = 32'h1234_5678,
   parameter logic [31:0] FSR_INIT   = 32'h0000_8A5F,
   localparam int OP_W    = 1 + EXP_W + FRAC_W,
   localparam int CR_W    = CR_FIELDS * CC_W,
   localparam int IDX_W   = (CR_FIELDS > 1) ? $clog2(CR_FIELDS) : 1,
   localparam int ALIGN_W = DEST_W - IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_ordered,
   input  logic [OP_W-1:0]  in_a,
   input  logic [OP_W-1:0]  in_b,
   input  logic [DEST_W-1:0] in_dest,
   output logic [CR_W-1:0]  cr_q,
   output logic [FSR_W-1:0] fsr_q,
   output logic             illegal_q,
   output logic             trap_q
);
   if (ALIGN_W < 0) begin : g_bad_dest
      $error("destination specifier narrower than field index");
   end
   if (FSR_CC_LSB + CC_W >= FSR_W) begin : g_bad_fsr
      $error("status condition bits do not fit");
   end
   if (CR_W > 32 || FSR_W > 32) begin : g_bad_init
      $error("register wider than reset constant");
   end

   logic [1:0]      nan_v, zero_v;
   logic [OP_W-1:0] ops [2];
   cc_e             code;
   logic            legal, nan_any, trap_c, do_write;
   logic [IDX_W-1:0] idx;
   logic [CR_W-1:0]  cr_nxt;
   logic [FSR_W-1:0] fsr_nxt;

   assign ops[0] = in_a;
   assign ops[1] = in_b;

   for (genvar k = 0; k < 2; k++) begin : g_cls
      fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
         .op     (ops[k]),
         .is_nan (nan_v[k]),
         .is_zero(zero_v[k])
      );
   end

   fpcmp_order #(.OP_W(OP_W)) u_order (
      .a     (in_a),
      .b     (in_b),
      .a_nan (nan_v[0]),
      .b_nan (nan_v[1]),
      .a_zero(zero_v[0]),
      .b_zero(zero_v[1]),
      .code  (code)
   );

   if (ALIGN_W > 0) begin : g_align
      assign legal = ~|in_dest[ALIGN_W-1:0];
      assign idx   = in_dest[DEST_W-1:ALIGN_W];
   end else begin : g_noalign
      assign legal = 1'b1;
      assign idx   = in_dest[IDX_W-1:0];
   end

   assign nan_any  = |nan_v;
   assign trap_c   = legal && in_ordered && nan_any;
   assign do_write = in_valid && legal && !trap_c;

   fpcmp_field_write #(.FIELDS(CR_FIELDS), .FIELD_W(CC_W)) u_crw (
      .cur(cr_q),
      .idx(idx),
      .val(code),
      .nxt(cr_nxt)
   );

   always_comb begin
      fsr_nxt = fsr_q;
      fsr_nxt[FSR_CC_LSB + CC_W] = 1'b0;
      fsr_nxt[FSR_CC_LSB +: CC_W] = code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr_q      <= CR_INIT[CR_W-1:0];
         fsr_q     <= FSR_INIT[FSR_W-1:0];
         illegal_q <= 1'b0;
         trap_q    <= 1'b0;
      end else begin
         illegal_q <= in_valid && !legal;
         trap_q    <= in_valid && trap_c;
         if (do_write) begin
            cr_q  <= cr_nxt;
            fsr_q <= fsr_nxt;
         end
      end
   end

   AST_UNORD_ON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
      nan_any |-> code == CC_UN); // R1
   AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      do_write |=> $countones(fsr_q[FSR_CC_LSB +: CC_W]) == 1); // R2
   AST_ZERO_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_v == 2'b11) |-> code == CC_EQ); // R3
   AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_q |-> $stable(cr_q) && $stable(fsr_q)); // R5
   AST_FSR_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      do_write |=> !fsr_q[FSR_CC_LSB + CC_W]); // R7
   AST_TRAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> $stable(cr_q) && $stable(fsr_q)); // R8
   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal_q && trap_q)); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cr_q) && $stable(fsr_q) && !illegal_q && !trap_q); // R9
endmodule

// File: tb/fp_compare_unit_bench.sv
module fp_compare_unit_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ordered = 1'b0;
   logic [63:0] in_a = '0;
   logic [63:0] in_b = '0;
   logic [4:0]  in_dest = '0;
   logic [31:0] cr_q, fsr_q;
   logic        illegal_q, trap_q;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   logic [31:0] exp_cr, exp_fsr;
   logic        exp_ill, exp_trap;

   localparam logic [63:0] P1    = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] P2    = 64'h4000_0000_0000_0000;
   localparam logic [63:0] P35   = 64'h400C_0000_0000_0000;
   localparam logic [63:0] N1    = 64'hBFF0_0000_0000_0000;
   localparam logic [63:0] N2    = 64'hC000_0000_0000_0000;
   localparam logic [63:0] PZ    = 64'h0000_0000_0000_0000;
   localparam logic [63:0] NZ    = 64'h8000_0000_0000_0000;
   localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] PMAX  = 64'h7FEF_FFFF_FFFF_FFFF;
   localparam logic [63:0] NMAX  = 64'hFFEF_FFFF_FFFF_FFFF;
   localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;
   localparam logic [63:0] NNAN  = 64'hFFF0_0000_0000_0001;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_compare_unit u_fp_compare_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ordered(in_ordered),
      .in_a      (in_a),
      .in_b      (in_b),
      .in_dest   (in_dest),
      .cr_q      (cr_q),
      .fsr_q     (fsr_q),
      .illegal_q (illegal_q),
      .trap_q    (trap_q)
   );

   function automatic bit is_nan(input logic [63:0] v);
      return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
   endfunction

   function automatic logic [3:0] ref_cc(input logic [63:0] a, input logic [63:0] b);
      real ra, rb;
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      if (is_nan(a) || is_nan(b)) return 4'b0001;
      if (ra == rb) return 4'b0010;
      if (ra < rb) return 4'b1000;
      return 4'b0100;
   endfunction

   task automatic compare_all(input string tag);
      total++;
      if (cr_q !== exp_cr || fsr_q !== exp_fsr || illegal_q !== exp_ill || trap_q !== exp_trap) begin
         bad++;
         $display("FAIL %s: actual cr=%h fsr=%h ill=%b trap=%b expected cr=%h fsr=%h ill=%b trap=%b",
                  tag, cr_q, fsr_q, illegal_q, trap_q, exp_cr, exp_fsr, exp_ill, exp_trap);
      end
   endtask

   task automatic step(input logic v, input logic ord, input logic [63:0] a,
                       input logic [63:0] b, input logic [4:0] dest, input string tag);
      int f;
      logic [3:0] cc;
      @(negedge clk);
      in_valid   = v;
      in_ordered = ord;
      in_a       = a;
      in_b       = b;
      in_dest    = dest;
      exp_ill  = 1'b0;
      exp_trap = 1'b0;
      if (v) begin
         cc = ref_cc(a, b);
         f  = int'(dest) / 4;
         if (dest % 4 != 0) exp_ill = 1'b1;
         else if (ord && (is_nan(a) || is_nan(b))) exp_trap = 1'b1;
         else begin
            exp_cr[31 - 4*f -: 4] = cc;
            exp_fsr[15]    = 1'b0;
            exp_fsr[14:11] = cc;
         end
      end
      @(posedge clk);
      #1;
      compare_all(tag);
   endtask

   initial begin
      int cycles = 0;
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      exp_cr   = 32'h1234_5678;
      exp_fsr  = 32'h0000_8A5F;
      exp_ill  = 1'b0;
      exp_trap = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      compare_all("R10 reset");
      @(negedge clk);
      rst_n = 1'b1;

      step(1, 0, P1,   P2,   5'd0,  "R2 R6 lt field0");
      step(1, 0, P2,   P1,   5'd4,  "R2 R6 gt field1");
      step(1, 0, P35,  P35,  5'd28, "R2 R6 eq field7");
      step(1, 0, PZ,   NZ,   5'd8,  "R3 +0 -0");
      step(1, 0, NZ,   PZ,   5'd12, "R3 -0 +0");
      step(1, 0, N1,   N2,   5'd16, "R4 neg gt");
      step(1, 0, N2,   N1,   5'd20, "R4 neg lt");
      step(1, 0, N1,   P1,   5'd24, "R4 sign lt");
      step(1, 0, PZ,   N1,   5'd24, "R4 zero vs neg");
      step(1, 0, PINF, PMAX, 5'd0,  "R4 +inf");
      step(1, 0, NINF, NMAX, 5'd4,  "R4 -inf");
      step(1, 0, PINF, PINF, 5'd8,  "R4 inf eq");
      step(1, 0, QNAN, P1,   5'd12, "R1 qnan a");
      step(1, 0, P1,   SNAN, 5'd16, "R1 low frac nan b");
      step(1, 0, NNAN, NNAN, 5'd20, "R1 neg nan both");
      step(1, 0, PMAX, PINF, 5'd28, "R1 inf not nan");
      step(1, 1, QNAN, P1,   5'd0,  "R8 ordered trap");
      step(1, 1, P1,   SNAN, 5'd4,  "R8 ordered trap b");
      step(1, 1, N2,   P35,  5'd8,  "R8 ordered no nan");
      step(1, 0, P1,   P2,   5'd1,  "R5 dest 1");
      step(1, 0, P2,   P1,   5'd2,  "R5 dest 2");
      step(1, 0, P35,  P35,  5'd31, "R5 dest 31");
      step(1, 1, QNAN, QNAN, 5'd3,  "R9 illegal over trap");
      step(0, 0, P1,   P2,   5'd0,  "R9 idle ignored");
      step(0, 1, QNAN, P1,   5'd1,  "R9 idle bad inputs ignored");
      step(1, 0, P35,  P2,   5'd12, "R6 field3 gt");
      step(1, 0, P1,   P1,   5'd28, "R7 eq after writes");
      step(0, 0, '0,   '0,   5'd0,  "R9 flags drop");

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule